// File: doc/BRIEF.md
# Lockdown-Aware Cache Way Victim Selector

This block chooses which way of an 8-way set-associative cache receives the next linefill. It holds a per-way lockdown mask. A way whose mask bit is set is never chosen. The remaining ways share allocations through a round-robin pointer. When every way is locked, the block answers a request with a no-allocate indication.

Software reads and writes the mask through a 32-bit register port. Each access carries a secure/non-secure qualifier and a privileged/user qualifier. A non-secure enable input decides whether non-secure privileged code may reach the register. Any access that is not permitted is flagged as undefined and leaves the register unchanged. A typical use is to open exactly one way and run loads so that lines fill into it, then lock that way so its contents stay resident.

Top module: `way_victim_sel`

## Requirements
- R1: After reset the mask is zero, the round-robin pointer is at way 0, and alloc_valid_o and cfg_rsp_valid_o are low.
- R2: A way whose mask bit is 1 is never returned as the allocation way.
- R3: An allocation returns the first unlocked way found by scanning upward from the pointer, wrapping from way 7 to way 0. The pointer then moves to the way after the one chosen.
- R4: When all 8 mask bits are 1, a request returns alloc_none_o=1 and the pointer does not move.
- R5: Register bit i (for i in 0..7) is the lock bit of way i. Write data in bits [31:8] is ignored, and reads return zero in bits [31:8].
- R6: A secure privileged access (cfg_secure_i=1, cfg_priv_i=1) may always read and write the register.
- R7: A non-secure privileged access succeeds only when ns_en_i=1. Otherwise cfg_undef_o=1, the read data is zero, and the mask is unchanged.
- R8: A user access (cfg_priv_i=0) is always flagged with cfg_undef_o=1 and never changes the mask, whatever the security state.
- R9: A mask write applies to allocation requests from the following cycle on. A request in the same cycle as the write uses the old mask.
- R10: alloc_valid_o and the result appear exactly one cycle after alloc_req_i. cfg_rsp_valid_o, cfg_rdata_o and cfg_undef_o appear exactly one cycle after cfg_req_i.
- R11: Writing zero to bits [7:0] unlocks every way, and allocation resumes from the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_req_i | input | 1 | Linefill allocation request |
| alloc_valid_o | output | 1 | Allocation result valid, one cycle after request |
| alloc_none_o | output | 1 | No way available (all locked) |
| alloc_way_o | output | 3 | Chosen victim way index |
| cfg_req_i | input | 1 | Register access request |
| cfg_we_i | input | 1 | 1 = write, 0 = read |
| cfg_wdata_i | input | 32 | Write data |
| cfg_secure_i | input | 1 | Access is from the secure state |
| cfg_priv_i | input | 1 | Access is privileged |
| ns_en_i | input | 1 | Grants non-secure privileged access |
| cfg_rsp_valid_o | output | 1 | Register response valid |
| cfg_undef_o | output | 1 | Access was not permitted |
| cfg_rdata_o | output | 32 | Read data |

## Verification
The bench aims at the pointer's behaviour around locked ways. It checks skipping over a locked run and the wrap from way 7 to way 0. A design that advanced the pointer by one instead of past the chosen way would return the same way twice. It checks the all-locked case, where a design that moved the pointer anyway would resume at the wrong way after an unlock. It checks the permission matrix for each qualifier combination, which catches a non-secure write that slips through with the enable low. It also checks reserved-bit masking and a request issued in the same cycle as a write, which catches a mask applied one cycle early.

// File: rtl/wvs_pkg.sv
package wvs_pkg;
  // access permission: secure privileged always, non-secure privileged when enabled
  function automatic logic cfg_permit(logic secure, logic priv, logic ns_en);
    return priv & (secure | ns_en);
  endfunction
endpackage

// File: rtl/wvs_lock_reg.sv
module wvs_lock_reg
  import wvs_pkg::*;
#(
  parameter int NUM_WAYS = 8,
  parameter int REG_W    = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cfg_req_i,
  input  logic                cfg_we_i,
  input  logic [REG_W-1:0]    cfg_wdata_i,
  input  logic                cfg_secure_i,
  input  logic                cfg_priv_i,
  input  logic                ns_en_i,
  output logic [NUM_WAYS-1:0] lock_mask_o,
  output logic                cfg_rsp_valid_o,
  output logic                cfg_undef_o,
  output logic [REG_W-1:0]    cfg_rdata_o
);
  logic [NUM_WAYS-1:0] mask_q;
  logic                permit;

  assign permit = cfg_permit(cfg_secure_i, cfg_priv_i, ns_en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q          <= '0;
      cfg_rsp_valid_o <= 1'b0;
      cfg_undef_o     <= 1'b0;
      cfg_rdata_o     <= '0;
    end else begin
      cfg_rsp_valid_o <= cfg_req_i;
      cfg_undef_o     <= cfg_req_i & ~permit;
      cfg_rdata_o     <= '0;
      if (cfg_req_i && permit) begin
        if (cfg_we_i) mask_q <= cfg_wdata_i[NUM_WAYS-1:0];
        else          cfg_rdata_o <= REG_W'(mask_q);
      end
    end
  end

  assign lock_mask_o = mask_q;

  a_r8_user_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i && !cfg_priv_i |=> cfg_undef_o && $stable(mask_q));
  a_r7_ns_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i && cfg_priv_i && !cfg_secure_i && !ns_en_i |=> cfg_undef_o && $stable(mask_q));
  a_r6_secure_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i && cfg_priv_i && cfg_secure_i |=> !cfg_undef_o);
  a_r10_cfg_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_i |=> cfg_rsp_valid_o);
  a_r5_resv_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rsp_valid_o |-> cfg_rdata_o[REG_W-1:NUM_WAYS] == '0);
endmodule

// File: rtl/wvs_rr_pick.sv
module wvs_rr_pick #(
  parameter int NUM_WAYS = 8,
  localparam int IDX_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [NUM_WAYS-1:0] lock_mask_i,
  output logic                valid_o,
  output logic                none_o,
  output logic [IDX_W-1:0]    way_o
);
  logic [IDX_W-1:0] ptr_q, pick, idx, ptr_nxt;
  logic             found;

  // first unlocked way at or above the pointer, wrapping
  always_comb begin
    found = 1'b0;
    pick  = ptr_q;
    idx   = '0;
    for (int k = 0; k < NUM_WAYS; k++) begin
      idx = IDX_W'((int'(ptr_q) + k) % NUM_WAYS);
      if (!found && !lock_mask_i[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end

  assign ptr_nxt = (int'(pick) == NUM_WAYS-1) ? '0 : pick + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      valid_o <= 1'b0;
      none_o  <= 1'b0;
      way_o   <= '0;
    end else begin
      valid_o <= req_i;
      none_o  <= req_i & ~found;
      way_o   <= (req_i && found) ? pick : '0;
      if (req_i && found) ptr_q <= ptr_nxt;
    end
  end

  a_r2_no_locked_pick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !none_o |-> ((($past(lock_mask_i) >> way_o) & NUM_WAYS'(1)) == '0));
  a_r4_full_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (&lock_mask_i) |=> none_o && $stable(ptr_q));
  a_r4_free_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !(&lock_mask_i) |=> !none_o);
  a_r10_alloc_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel #(
  parameter int NUM_WAYS = 8,
  parameter int REG_W    = 32,
  localparam int IDX_W   = $clog2(NUM_WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_req_i,
  output logic             alloc_valid_o,
  output logic             alloc_none_o,
  output logic [IDX_W-1:0] alloc_way_o,
  input  logic             cfg_req_i,
  input  logic             cfg_we_i,
  input  logic [REG_W-1:0] cfg_wdata_i,
  input  logic             cfg_secure_i,
  input  logic             cfg_priv_i,
  input  logic             ns_en_i,
  output logic             cfg_rsp_valid_o,
  output logic             cfg_undef_o,
  output logic [REG_W-1:0] cfg_rdata_o
);
  logic [NUM_WAYS-1:0] lock_mask;

  wvs_lock_reg #(.NUM_WAYS(NUM_WAYS), .REG_W(REG_W)) u_lock (
    .clk_i, .rst_ni, .cfg_req_i, .cfg_we_i, .cfg_wdata_i, .cfg_secure_i,
    .cfg_priv_i, .ns_en_i, .lock_mask_o(lock_mask), .cfg_rsp_valid_o,
    .cfg_undef_o, .cfg_rdata_o
  );

  wvs_rr_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .clk_i, .rst_ni, .req_i(alloc_req_i), .lock_mask_i(lock_mask),
    .valid_o(alloc_valid_o), .none_o(alloc_none_o), .way_o(alloc_way_o)
  );
endmodule

// File: tb/sim_way_victim_sel.sv
module sim_way_victim_sel;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        alloc_req = 0, cfg_req = 0, cfg_we = 0, cfg_sec = 0, cfg_priv = 0, ns_en = 0;
  logic [31:0] cfg_wdata = '0;
  logic        alloc_valid, alloc_none, rsp_valid, undef;
  logic [2:0]  alloc_way;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_mask = '0;
  int         exp_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  way_victim_sel u0 (
    .clk_i(clk), .rst_ni(rst_n), .alloc_req_i(alloc_req), .alloc_valid_o(alloc_valid),
    .alloc_none_o(alloc_none), .alloc_way_o(alloc_way), .cfg_req_i(cfg_req),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_secure_i(cfg_sec),
    .cfg_priv_i(cfg_priv), .ns_en_i(ns_en), .cfg_rsp_valid_o(rsp_valid),
    .cfg_undef_o(undef), .cfg_rdata_o(rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected way for the model; -1 means none
  function automatic int model_pick();
    for (int k = 0; k < 8; k++) begin
      int w = (exp_ptr + k) % 8;
      if (!exp_mask[w]) return w;
    end
    return -1;
  endfunction

  task automatic cfg(bit we, logic [31:0] d, bit sec, bit priv, bit nse);
    @(negedge clk);
    cfg_req = 1; cfg_we = we; cfg_wdata = d; cfg_sec = sec; cfg_priv = priv; ns_en = nse;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0;
    check("R10 cfg rsp valid", {31'b0, rsp_valid}, 32'd1);
    if (we && priv && (sec || nse)) exp_mask = d[7:0];
  endtask

  task automatic alloc_one(string tag);
    int e;
    e = model_pick();
    @(negedge clk);
    alloc_req = 1;
    @(negedge clk);
    alloc_req = 0;
    check({tag, " valid (R10)"}, {31'b0, alloc_valid}, 32'd1);
    if (e < 0) begin
      check({tag, " none (R4)"}, {31'b0, alloc_none}, 32'd1);
    end else begin
      check({tag, " none"}, {31'b0, alloc_none}, 32'd0);
      check({tag, " way (R2 R3)"}, {29'b0, alloc_way}, 32'(e));
      exp_ptr = (e + 1) % 8;
    end
  endtask

  task automatic t_reset();
    check("R1 alloc_valid idle", {31'b0, alloc_valid}, 0);
    check("R1 rsp_valid idle", {31'b0, rsp_valid}, 0);
    cfg(0, 0, 1, 1, 0);
    check("R1 mask zero", rdata, 0);
  endtask

  task automatic t_round_robin();
    for (int i = 0; i < 9; i++) alloc_one("R3 rr");
  endtask

  task automatic t_lock_skip();
    cfg(1, 32'h0000_00C6, 1, 1, 0);       // ways 1,2,6,7 locked
    check("R6 secure write ok", {31'b0, undef}, 0);
    for (int i = 0; i < 6; i++) alloc_one("R2 skip");
  endtask

  task automatic t_reserved();
    cfg(1, 32'hABCD_EF05, 1, 1, 0);
    cfg(0, 0, 1, 1, 0);
    check("R5 reserved ignored, readback", rdata, 32'h0000_0005);
    check("R6 secure read ok", {31'b0, undef}, 0);
  endtask

  task automatic t_permissions();
    cfg(1, 32'h33, 0, 1, 0);
    check("R7 ns blocked undef", {31'b0, undef}, 1);
    cfg(0, 0, 0, 1, 0);
    check("R7 ns blocked read undef", {31'b0, undef}, 1);
    check("R7 ns blocked read zero", rdata, 0);
    cfg(1, 32'h11, 1, 0, 1);
    check("R8 secure user undef", {31'b0, undef}, 1);
    cfg(1, 32'h22, 0, 0, 1);
    check("R8 ns user undef", {31'b0, undef}, 1);
    cfg(0, 0, 1, 1, 0);
    check("R7 R8 mask unchanged", rdata, 32'h05);
    cfg(1, 32'h3C, 0, 1, 1);
    check("R7 ns enabled write", {31'b0, undef}, 0);
    cfg(0, 0, 0, 1, 1);
    check("R7 ns enabled read", rdata, 32'h3C);
    alloc_one("R2 after ns write");
  endtask

  task automatic t_all_locked();
    cfg(1, 32'hFF, 1, 1, 0);
    alloc_one("R4 full");
    alloc_one("R4 full again");
    cfg(1, 32'h00, 1, 1, 0);
    for (int i = 0; i < 3; i++) alloc_one("R11 unlocked");
  endtask

  task automatic t_same_cycle();
    int e_old;
    e_old = model_pick();
    @(negedge clk);
    cfg_req = 1; cfg_we = 1; cfg_wdata = 32'hFF; cfg_sec = 1; cfg_priv = 1; alloc_req = 1;
    @(negedge clk);
    cfg_req = 0; cfg_we = 0; alloc_req = 0;
    check("R9 same-cycle uses old mask", {28'b0, alloc_none, alloc_way}, 32'(e_old));
    exp_ptr = (e_old + 1) % 8;
    exp_mask = 8'hFF;
    alloc_one("R9 next cycle new mask");
    cfg(1, 0, 1, 1, 0);
    alloc_one("R11 zero unlock");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_round_robin();
    t_lock_skip();
    t_reserved();
    t_permissions();
    t_all_locked();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule